// File: doc/BRIEF.md
# Pattern and Nametable Bank Mapper

This block sits between a picture-processor address bus and the cartridge memories of a tile-based video system. The CPU programs it through byte writes. Each pattern bank is sixteen bits wide and is built from its own high and low byte registers. Each nametable bank is built the same way from its own pair of byte registers. Two control bytes choose the pattern bank granularity, ask for nametables to be read from ROM, and set the mirroring arrangement.

For every picture-side address below $3000, the block returns three things with no clock delay. The first is a 16-bit number of a 1 KB page. The second is a flag that selects ROM or the internal nametable RAM. The third is the A10 line for that internal RAM. Pattern fetches always come from ROM. The page number is the chosen bank scaled by the bank size, plus the address bits that fall inside the bank. Nametable fetches come from ROM only when a request flag is set. A guard clears that flag whenever the nametable registers hold an identity entry. Otherwise the fetch goes to the internal RAM, following the chosen mirroring.

Top module: `ppu_bank_mapper`

## Requirements
- R1: A CPU write is decoded on address AND $F007. Masked $9000+i loads the low byte of pattern entry i (i = bits 2:0). Masked $A000+i loads the high byte. The bank value of an entry is high·256 + low.
- R2: After reset, the low byte of pattern entry i is i, and every high byte and every nametable byte is 0. The granularity is 8 KB, the mirroring is vertical, and ROM nametables are off.
- R3: When granularity is 0, pattern page = bank0·8 + A[12:10], truncated to 16 bits.
- R4: When granularity is 1, entry 0 serves A12=0 and entry 4 serves A12=1, and page = bank·4 + A[11:10].
- R5: When granularity is 2, entries 0, 2, 4 and 6 serve A[12:11] = 0, 1, 2 and 3, and page = bank·2 + A10.
- R6: When granularity is 3, entry A[12:10] serves the access, and page = bank.
- R7: A pattern access (A13=0) always gives rom_sel=1 and ciram_a10=0.
- R8: A write to $D000 sets granularity from bits 4:3 and the ROM-nametable request from bit 5. Masked $B000–$B003 loads the nametable low bytes and $B004–$B007 loads the high bytes. While ROM nametables are active, an access with A13=1 gives rom_sel=1, ciram_a10=0 and page = nametable bank A[11:10].
- R9: The request is checked each time $D000 or a nametable byte is written, using the values after that write. If any entry i has a high byte of 0 and a low byte equal to i, the request is cleared. Once cleared, it stays cleared until $D000 is written again.
- R10: A write to $D001 sets mirroring from bits 1:0. With ROM nametables off, an access with A13=1 gives rom_sel=0. Mode 0 gives ciram_a10=A10 and page=A10. Mode 1 gives ciram_a10=A11 and page=A11. Modes 2 and 3 give ciram_a10=A10 and page=A[11:10].
- R11: Writes to any other masked address, such as $8000 or $D002, change no output.
- R12: With wr_en low, the values on wr_addr and wr_data change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-side fetch address |
| page | output | 16 | 1 KB page number, or nametable screen index when ROM is not selected |
| rom_sel | output | 1 | 1 selects ROM, 0 selects internal nametable RAM |
| ciram_a10 | output | 1 | A10 line of the internal nametable RAM |

## Verification
The bench walks through all four granularities with banks that have both bytes set. A design that swapped the high and low bytes, or picked the wrong entry for an address quarter, would return pages far from the expected ones. One bank is large enough that scaling overflows 16 bits, which catches a design that saturates or widens instead of truncating. The identity guard is tested three ways: it fires at once from the reset contents, it stays cleared after the identity entry is removed, and it fires again when a later nametable write recreates an identity entry. A guard that re-armed itself, or that tested the old register values, would leave ROM nametables selected. Aliased addresses, undecoded addresses and writes with the strobe low are also applied; a looser decoder would corrupt the banks.

// File: rtl/ppu_bank_pkg.sv
// Package: shared constants and types for the pattern/nametable bank mapper.
// Assumes the CPU decode uses address AND DEC_MASK and that decoded
// register groups sit at the bases below.
package ppu_bank_pkg;

    localparam int BYTE_W   = 8;
    localparam int CPU_AW   = 16;
    localparam int PPU_AW   = 14;
    localparam int PAT_CNT  = 8;
    localparam int NT_CNT   = 4;
    localparam int BANK_W   = 2 * BYTE_W;

    localparam logic [CPU_AW-1:0] DEC_MASK     = 16'hF007;
    localparam logic [CPU_AW-1:0] PAT_LO_BASE  = 16'h9000;
    localparam logic [CPU_AW-1:0] PAT_HI_BASE  = 16'hA000;
    localparam logic [CPU_AW-1:0] NT_BASE      = 16'hB000;
    localparam logic [CPU_AW-1:0] CTRL_ADDR    = 16'hD000;
    localparam logic [CPU_AW-1:0] MIRR_ADDR    = 16'hD001;

    // Bank granularity for pattern space.
    typedef enum logic [1:0] {
        GRAN_8K = 2'd0,
        GRAN_4K = 2'd1,
        GRAN_2K = 2'd2,
        GRAN_1K = 2'd3
    } gran_e;

    // Internal nametable RAM arrangement.
    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_QUADA = 2'd2,
        MIR_QUADB = 2'd3
    } mirr_e;

endpackage

// File: rtl/ppu_bank_regs.sv
// Module: bank byte register file.
// Holds the low and high bytes of every pattern entry and every nametable
// entry, and loads them from decoded CPU writes. Besides the registered
// values, it exports the next-state nametable bytes so the control logic
// can judge the contents that a write is about to produce.
// Assumes one write per wr_en cycle.
module ppu_bank_regs
    import ppu_bank_pkg::*;
#(
    parameter int DW     = BYTE_W,
    parameter int AW     = CPU_AW,
    parameter int N_PAT  = PAT_CNT,
    parameter int N_NT   = NT_CNT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [N_PAT-1:0][DW-1:0] pat_lo_q,
    output logic [N_PAT-1:0][DW-1:0] pat_hi_q,
    output logic [N_NT-1:0][DW-1:0]  nt_lo_q,
    output logic [N_NT-1:0][DW-1:0]  nt_hi_q,
    output logic [N_NT-1:0][DW-1:0]  nt_lo_d,
    output logic [N_NT-1:0][DW-1:0]  nt_hi_d,
    output logic                     nt_wr
);

    localparam int PIDX_W = $clog2(N_PAT);
    localparam int NIDX_W = $clog2(N_NT);

    logic [AW-1:0]     masked;
    logic              pat_lo_hit;
    logic              pat_hi_hit;
    logic              nt_hit;
    logic              nt_high_half;
    logic [PIDX_W-1:0] pat_idx;
    logic [NIDX_W-1:0] nt_idx;

    // Purpose: decode the masked write address into a register group and index.
    always_comb begin
        masked       = wr_addr & DEC_MASK;
        pat_lo_hit   = wr_en && (masked[AW-1:3] == PAT_LO_BASE[AW-1:3]);
        pat_hi_hit   = wr_en && (masked[AW-1:3] == PAT_HI_BASE[AW-1:3]);
        nt_hit       = wr_en && (masked[AW-1:3] == NT_BASE[AW-1:3]);
        nt_high_half = masked[2];
        pat_idx      = masked[PIDX_W-1:0];
        nt_idx       = masked[NIDX_W-1:0];
    end

    assign nt_wr = nt_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_PAT; gi++) begin : g_pat
            // Purpose: low byte of pattern entry gi, reset to its own index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pat_lo_q[gi] <= DW'(gi);
                else if (pat_lo_hit && (pat_idx == PIDX_W'(gi)))
                    pat_lo_q[gi] <= wr_data;
            end

            // Purpose: high byte of pattern entry gi, reset to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pat_hi_q[gi] <= '0;
                else if (pat_hi_hit && (pat_idx == PIDX_W'(gi)))
                    pat_hi_q[gi] <= wr_data;
            end
        end

        for (gi = 0; gi < N_NT; gi++) begin : g_nt
            // Purpose: next-state value of nametable entry gi after this cycle's write.
            always_comb begin
                nt_lo_d[gi] = nt_lo_q[gi];
                nt_hi_d[gi] = nt_hi_q[gi];
                if (nt_hit && (nt_idx == NIDX_W'(gi))) begin
                    if (nt_high_half)
                        nt_hi_d[gi] = wr_data;
                    else
                        nt_lo_d[gi] = wr_data;
                end
            end

            // Purpose: hold nametable entry gi, cleared at reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    nt_lo_q[gi] <= '0;
                    nt_hi_q[gi] <= '0;
                end else begin
                    nt_lo_q[gi] <= nt_lo_d[gi];
                    nt_hi_q[gi] <= nt_hi_d[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ppu_nt_ctrl.sv
// Module: control fields and ROM-nametable guard.
// Captures granularity and mirroring from the two control addresses. It
// keeps the ROM-nametable flag, which is set only by a control write with
// the request bit and is cleared when the next-state nametable contents
// include an identity entry (high byte zero, low byte equal to the index).
// Assumes nt_lo_d/nt_hi_d are the values the register file will hold next.
module ppu_nt_ctrl
    import ppu_bank_pkg::*;
#(
    parameter int DW   = BYTE_W,
    parameter int AW   = CPU_AW,
    parameter int N_NT = NT_CNT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [N_NT-1:0][DW-1:0] nt_lo_d,
    input  logic [N_NT-1:0][DW-1:0] nt_hi_d,
    input  logic                    nt_wr,
    output gran_e                   gran,
    output mirr_e                   mirr,
    output logic                    nt_rom
);

    logic [AW-1:0] masked;
    logic          ctrl_hit;
    logic          mirr_hit;
    logic          ident_seen;
    logic          unused_data_bits;

    assign unused_data_bits = ^{wr_data[DW-1:6], wr_data[2]};

    // Purpose: recognise the two control write addresses.
    always_comb begin
        masked   = wr_addr & DEC_MASK;
        ctrl_hit = wr_en && (masked == CTRL_ADDR);
        mirr_hit = wr_en && (masked == MIRR_ADDR);
    end

    // Purpose: search the next-state nametable contents for an identity entry.
    always_comb begin
        ident_seen = 1'b0;
        for (int i = 0; i < N_NT; i++) begin
            if ((nt_hi_d[i] == '0) && (nt_lo_d[i] == DW'(i)))
                ident_seen = 1'b1;
        end
    end

    // Purpose: granularity field, taken from bits 4:3 of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gran <= GRAN_8K;
        else if (ctrl_hit)
            gran <= gran_e'(wr_data[4:3]);
    end

    // Purpose: mirroring field, taken from bits 1:0 of a mirroring write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mirr <= MIR_VERT;
        else if (mirr_hit)
            mirr <= mirr_e'(wr_data[1:0]);
    end

    // Purpose: ROM-nametable flag; only a control write can set it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nt_rom <= 1'b0;
        else if (ctrl_hit)
            nt_rom <= wr_data[5] && !ident_seen;
        else if (nt_wr && ident_seen)
            nt_rom <= 1'b0;
    end

endmodule

// File: rtl/ppu_page_calc.sv
// Module: combinational page resolver.
// Turns a picture-side address into a 1 KB page, a ROM/RAM select and the
// internal RAM A10 line. In pattern space, it picks a pattern entry by
// granularity and scales it. In nametable space, it either returns a
// nametable bank or routes the access to the internal RAM according to the
// mirroring mode. Assumes the address is below $3000 or mirrors that range.
module ppu_page_calc
    import ppu_bank_pkg::*;
#(
    parameter int DW    = BYTE_W,
    parameter int PW    = PPU_AW,
    parameter int N_PAT = PAT_CNT,
    parameter int N_NT  = NT_CNT
) (
    input  logic [PW-1:0]            ppu_addr,
    input  gran_e                    gran,
    input  mirr_e                    mirr,
    input  logic                     nt_rom,
    input  logic [N_PAT-1:0][DW-1:0] pat_lo_q,
    input  logic [N_PAT-1:0][DW-1:0] pat_hi_q,
    input  logic [N_NT-1:0][DW-1:0]  nt_lo_q,
    input  logic [N_NT-1:0][DW-1:0]  nt_hi_q,
    output logic [2*DW-1:0]          page,
    output logic                     rom_sel,
    output logic                     ciram_a10
);

    localparam int BW     = 2 * DW;
    localparam int PIDX_W = $clog2(N_PAT);
    localparam int NIDX_W = $clog2(N_NT);
    localparam int WIDE_W = BW + PIDX_W;

    logic [PIDX_W-1:0] pat_idx;
    logic [PIDX_W-1:0] sub_page;
    logic [1:0]        shift;
    logic [BW-1:0]     pat_bank;
    logic [WIDE_W-1:0] pat_wide;
    logic [NIDX_W-1:0] nt_idx;
    logic [BW-1:0]     nt_bank;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^ppu_addr[9:0];

    // Purpose: choose the pattern entry, the scaling and the in-bank offset per granularity.
    always_comb begin
        unique case (gran)
            GRAN_8K: begin
                pat_idx  = '0;
                shift    = 2'd3;
                sub_page = ppu_addr[12:10];
            end
            GRAN_4K: begin
                pat_idx  = {ppu_addr[12], 2'b00};
                shift    = 2'd2;
                sub_page = {1'b0, ppu_addr[11:10]};
            end
            GRAN_2K: begin
                pat_idx  = {ppu_addr[12:11], 1'b0};
                shift    = 2'd1;
                sub_page = {2'b00, ppu_addr[10]};
            end
            default: begin
                pat_idx  = ppu_addr[12:10];
                shift    = 2'd0;
                sub_page = '0;
            end
        endcase
    end

    // Purpose: form the scaled pattern page, wide enough before truncation.
    always_comb begin
        pat_bank = {pat_hi_q[pat_idx], pat_lo_q[pat_idx]};
        pat_wide = ({{PIDX_W{1'b0}}, pat_bank} << shift) | {{BW{1'b0}}, sub_page};
    end

    // Purpose: fetch the nametable bank addressed by the screen quadrant.
    always_comb begin
        nt_idx  = ppu_addr[11:10];
        nt_bank = {nt_hi_q[nt_idx], nt_lo_q[nt_idx]};
    end

    // Purpose: final output mux between pattern, ROM nametable and internal RAM.
    always_comb begin
        if (!ppu_addr[13]) begin
            page      = pat_wide[BW-1:0];
            rom_sel   = 1'b1;
            ciram_a10 = 1'b0;
        end else if (nt_rom) begin
            page      = nt_bank;
            rom_sel   = 1'b1;
            ciram_a10 = 1'b0;
        end else begin
            rom_sel = 1'b0;
            unique case (mirr)
                MIR_VERT: begin
                    ciram_a10 = ppu_addr[10];
                    page      = {{(BW-1){1'b0}}, ppu_addr[10]};
                end
                MIR_HORZ: begin
                    ciram_a10 = ppu_addr[11];
                    page      = {{(BW-1){1'b0}}, ppu_addr[11]};
                end
                default: begin
                    ciram_a10 = ppu_addr[10];
                    page      = {{(BW-2){1'b0}}, ppu_addr[11:10]};
                end
            endcase
        end
    end

endmodule

// File: rtl/ppu_bank_mapper.sv
// Module: top of the pattern/nametable bank mapper.
// Connects the byte register file, the control/guard logic and the
// combinational page resolver. Outputs follow ppu_addr with no clock delay.
// A register write takes effect from the clock edge that samples wr_en.
module ppu_bank_mapper
    import ppu_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [BANK_W-1:0] page,
    output logic              rom_sel,
    output logic              ciram_a10
);

    logic [PAT_CNT-1:0][BYTE_W-1:0] pat_lo_q;
    logic [PAT_CNT-1:0][BYTE_W-1:0] pat_hi_q;
    logic [NT_CNT-1:0][BYTE_W-1:0]  nt_lo_q;
    logic [NT_CNT-1:0][BYTE_W-1:0]  nt_hi_q;
    logic [NT_CNT-1:0][BYTE_W-1:0]  nt_lo_d;
    logic [NT_CNT-1:0][BYTE_W-1:0]  nt_hi_d;
    logic                           nt_wr;
    gran_e                          gran;
    mirr_e                          mirr;
    logic                           nt_rom;

    ppu_bank_regs #(
        .DW(BYTE_W), .AW(CPU_AW), .N_PAT(PAT_CNT), .N_NT(NT_CNT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pat_lo_q (pat_lo_q),
        .pat_hi_q (pat_hi_q),
        .nt_lo_q  (nt_lo_q),
        .nt_hi_q  (nt_hi_q),
        .nt_lo_d  (nt_lo_d),
        .nt_hi_d  (nt_hi_d),
        .nt_wr    (nt_wr)
    );

    ppu_nt_ctrl #(
        .DW(BYTE_W), .AW(CPU_AW), .N_NT(NT_CNT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .nt_lo_d (nt_lo_d),
        .nt_hi_d (nt_hi_d),
        .nt_wr   (nt_wr),
        .gran    (gran),
        .mirr    (mirr),
        .nt_rom  (nt_rom)
    );

    ppu_page_calc #(
        .DW(BYTE_W), .PW(PPU_AW), .N_PAT(PAT_CNT), .N_NT(NT_CNT)
    ) u_calc (
        .ppu_addr  (ppu_addr),
        .gran      (gran),
        .mirr      (mirr),
        .nt_rom    (nt_rom),
        .pat_lo_q  (pat_lo_q),
        .pat_hi_q  (pat_hi_q),
        .nt_lo_q   (nt_lo_q),
        .nt_hi_q   (nt_hi_q),
        .page      (page),
        .rom_sel   (rom_sel),
        .ciram_a10 (ciram_a10)
    );

endmodule

// File: rtl/ppu_bank_mapper_chk.sv
// Module: property checker for the bank mapper, bound to the top.
// Observes the ports plus the ROM-nametable flag and the first nametable
// high byte.
module ppu_bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic [13:0] ppu_addr,
    input logic [15:0] page,
    input logic        rom_sel,
    input logic        ciram_a10,
    input logic        nt_rom,
    input logic [7:0]  nt_hi0
);

    logic [15:0] masked;
    assign masked = wr_addr & 16'hF007;

    // Pattern fetches are always served from ROM with the RAM line low.
    assert_pattern_rom_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_addr[13] |-> (rom_sel && !ciram_a10));

    // Internal-RAM nametable fetches expose only a screen index.
    assert_ciram_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[13] && !rom_sel) |-> (page[15:2] == 14'd0));

    // The ROM-nametable flag only rises after a control write with bit 5 set.
    assert_nt_rom_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nt_rom) |-> $past(wr_en && (masked == 16'hD000) && wr_data[5]));

    // Writing zero to the first low byte while its high byte is zero forms an identity entry.
    assert_identity_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (masked == 16'hB000) && (wr_data == 8'h00) && (nt_hi0 == 8'h00))
        |=> !nt_rom);

    // With no write strobe and a steady fetch address, outputs hold.
    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(ppu_addr) ||
                    ($stable(page) && $stable(rom_sel) && $stable(ciram_a10))));

endmodule

bind ppu_bank_mapper ppu_bank_mapper_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ppu_addr  (ppu_addr),
    .page      (page),
    .rom_sel   (rom_sel),
    .ciram_a10 (ciram_a10),
    .nt_rom    (nt_rom),
    .nt_hi0    (nt_hi_q[0])
);

// File: tb/test_ppu_bank_mapper.sv
`timescale 1ns/1ps
// Bench: table-driven walk through granularities, mirroring and the
// ROM-nametable guard, then directed checks for reset and a strobe-less write.
module test_ppu_bank_mapper;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [13:0] ppu_addr = '0;
    logic [15:0] page;
    logic        rom_sel;
    logic        ciram_a10;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ppu_bank_mapper i_ppu_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ppu_addr(ppu_addr), .page(page),
        .rom_sel(rom_sel), .ciram_a10(ciram_a10)
    );

    // kind: 0 no write, 1 strobed write, 2 bus values without strobe
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic [13:0] paddr;
        logic [15:0] epage;
        logic        erom;
        logic        ea10;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 16'hD000, 8'h18, 14'h0C00, 16'h0003, 1'b1, 1'b0, 4'd6},  // R6 R2 reset low byte
        '{2'd0, 16'h0000, 8'h00, 14'h1C00, 16'h0007, 1'b1, 1'b0, 4'd6},  // R6
        '{2'd1, 16'h9005, 8'h34, 14'h1400, 16'h0034, 1'b1, 1'b0, 4'd1},  // R1
        '{2'd1, 16'hA005, 8'h12, 14'h1400, 16'h1234, 1'b1, 1'b0, 4'd1},  // R1 high byte
        '{2'd1, 16'h9F0B, 8'hAB, 14'h0C00, 16'h00AB, 1'b1, 1'b0, 4'd1},  // R1 alias
        '{2'd1, 16'h9000, 8'h21, 14'h0000, 16'h0021, 1'b1, 1'b0, 4'd1},  // R1
        '{2'd1, 16'hA000, 8'h01, 14'h0000, 16'h0121, 1'b1, 1'b0, 4'd1},  // R1
        '{2'd1, 16'hD000, 8'h00, 14'h1C00, 16'h090F, 1'b1, 1'b0, 4'd3},  // R3
        '{2'd0, 16'h0000, 8'h00, 14'h0800, 16'h090A, 1'b1, 1'b0, 4'd3},  // R3
        '{2'd1, 16'hA000, 8'h3F, 14'h0400, 16'hF909, 1'b1, 1'b0, 4'd3},  // R3 truncation
        '{2'd1, 16'hD000, 8'h08, 14'h0C00, 16'hFC87, 1'b1, 1'b0, 4'd4},  // R4
        '{2'd0, 16'h0000, 8'h00, 14'h1800, 16'h0012, 1'b1, 1'b0, 4'd4},  // R4 upper half
        '{2'd1, 16'h9004, 8'h50, 14'h1400, 16'h0141, 1'b1, 1'b0, 4'd4},  // R4
        '{2'd1, 16'hD000, 8'h10, 14'h0400, 16'h7E43, 1'b1, 1'b0, 4'd5},  // R5 entry 0
        '{2'd0, 16'h0000, 8'h00, 14'h0C00, 16'h0005, 1'b1, 1'b0, 4'd5},  // R5 entry 2
        '{2'd0, 16'h0000, 8'h00, 14'h1000, 16'h00A0, 1'b1, 1'b0, 4'd5},  // R5 entry 4
        '{2'd0, 16'h0000, 8'h00, 14'h1800, 16'h000C, 1'b1, 1'b0, 4'd5},  // R5 entry 6
        '{2'd1, 16'h8000, 8'hFF, 14'h0400, 16'h7E43, 1'b1, 1'b0, 4'd11}, // R11
        '{2'd1, 16'hD002, 8'h00, 14'h0400, 16'h7E43, 1'b1, 1'b0, 4'd11}, // R11
        '{2'd1, 16'hD001, 8'h01, 14'h2400, 16'h0000, 1'b0, 1'b0, 4'd10}, // R10 horizontal
        '{2'd0, 16'h0000, 8'h00, 14'h2800, 16'h0001, 1'b0, 1'b1, 4'd10}, // R10
        '{2'd1, 16'hD001, 8'h02, 14'h2C00, 16'h0003, 1'b0, 1'b1, 4'd10}, // R10 four-screen
        '{2'd1, 16'hD001, 8'h03, 14'h2800, 16'h0002, 1'b0, 1'b0, 4'd10}, // R10
        '{2'd1, 16'hD001, 8'h00, 14'h2C00, 16'h0001, 1'b0, 1'b1, 4'd10}, // R10 vertical
        '{2'd1, 16'hD000, 8'h30, 14'h2000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 reset identity
        '{2'd1, 16'hB000, 8'h10, 14'h2000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 sticky
        '{2'd1, 16'hD000, 8'h30, 14'h2000, 16'h0010, 1'b1, 1'b0, 4'd8},  // R8
        '{2'd1, 16'hB005, 8'h22, 14'h2400, 16'h2200, 1'b1, 1'b0, 4'd8},  // R8 high byte
        '{2'd1, 16'hB003, 8'h77, 14'h2C00, 16'h0077, 1'b1, 1'b0, 4'd8},  // R8
        '{2'd0, 16'h0000, 8'h00, 14'h1000, 16'h00A0, 1'b1, 1'b0, 4'd7},  // R7
        '{2'd1, 16'hB002, 8'h02, 14'h2800, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 new identity
        '{2'd1, 16'hB002, 8'h09, 14'h2800, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 stays cleared
        '{2'd1, 16'hD000, 8'h20, 14'h2800, 16'h0009, 1'b1, 1'b0, 4'd8},  // R8 re-armed
        '{2'd1, 16'hD000, 8'h00, 14'h2800, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 request off
        '{2'd2, 16'h9000, 8'h99, 14'h0000, 16'hF908, 1'b1, 1'b0, 4'd12}, // R12
        '{2'd2, 16'hD000, 8'h18, 14'h0000, 16'hF908, 1'b1, 1'b0, 4'd12}, // R12
        '{2'd0, 16'h0000, 8'h00, 14'h2400, 16'h0001, 1'b0, 1'b1, 4'd10}  // R10
    };

    task automatic check(input int req, input logic [15:0] ep, input logic er, input logic ea);
        n_chk++;
        if (page !== ep || rom_sel !== er || ciram_a10 !== ea) begin
            n_bad++;
            $display("FAIL R%0d addr=%h actual page=%h rom=%b a10=%b expected page=%h rom=%b a10=%b",
                     req, ppu_addr, page, rom_sel, ciram_a10, ep, er, ea);
        end
    endtask

    task automatic cpu_write(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic look(input logic [13:0] a);
        @(negedge clk);
        ppu_addr = a;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R2: reset state, 8 KB granularity with bank 0 and vertical mirroring
        look(14'h1C00); check(2, 16'h0007, 1'b1, 1'b0);
        look(14'h0400); check(2, 16'h0001, 1'b1, 1'b0);
        look(14'h2400); check(2, 16'h0001, 1'b0, 1'b1);
        look(14'h2800); check(2, 16'h0000, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].kind != 2'd0)
                cpu_write(VEC[k].kind == 2'd1, VEC[k].waddr, VEC[k].wdata);
            look(VEC[k].paddr);
            check(int'(VEC[k].req), VEC[k].epage, VEC[k].erom, VEC[k].ea10);
        end

        // R2: a reset in mid-run restores the entry indices and clears the flag
        cpu_write(1'b1, 16'h9006, 8'hEE);
        cpu_write(1'b1, 16'hB000, 8'h10);
        cpu_write(1'b1, 16'hD000, 8'h38);
        do_reset();
        look(14'h1C00); check(2, 16'h0007, 1'b1, 1'b0);
        look(14'h2C00); check(2, 16'h0001, 1'b0, 1'b1);
        cpu_write(1'b1, 16'hD000, 8'h18);
        look(14'h1800); check(2, 16'h0006, 1'b1, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule